// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Load Lookup

This block performs the lookup step of a load path into a set-associative L1 data cache. It selects the set with address bits that lie inside the page offset, so those bits never change under translation. The tag and data arrays can therefore be read straight from the virtual address. In the same cycle, a small fully associative translation buffer maps the virtual page number to a physical page number. That physical page number is then compared with the tag stored in every way.

Each accepted request gives exactly one registered outcome, one cycle later: a hit with the selected 32-bit word, a cache miss, a translation miss, or a permission fault. Outside logic handles misses. It installs lines through a refill port and translations through a translation fill port. A flush input invalidates every line and every translation in a single cycle.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset no response is pending, and every translation entry and cache line is invalid, so the first lookup reports a translation miss.
- R2: A request accepted while flush is low produces exactly one response in the next cycle. On that response exactly one of hit, miss, translation miss or fault is set.
- R3: When no valid translation entry holds the page number in address bits 31..12, the response is a translation miss with data 0 and physical address 0.
- R4: A hit needs a translation hit, granted permission, and a valid way whose stored 20-bit tag equals the translated page number. The returned word is selected by address bits 5..2, and word k is bits 32k+31..32k of the line.
- R5: With a translation hit and granted permission but no matching way, the response is a miss. Its physical address is the translated page number followed by address bits 11..0.
- R6: The set is taken from untranslated address bits 11..6 and the tag compare uses the physical page number, so two virtual pages mapped to one physical page reach the same line.
- R7: The permission field is bit 0 read, bit 1 write and bit 2 user. A load needs read, a store needs write, and a user-mode access also needs user. A violation reports a fault with data 0 even when the line is present.
- R8: A refill takes the tag from line-address bits 25..6 and the set from bits 5..0. It writes the next way of that set's round-robin pointer, which starts at way 0 after reset and advances after each such refill, so a fifth distinct tag in a set evicts the first.
- R9: A refill whose tag is already valid in the set overwrites that way and does not advance the set's pointer.
- R10: A translation fill whose page number is already present overwrites that entry and does not advance the pointer. Otherwise it writes the entry at a round-robin pointer over the 8 entries, starting at entry 0.
- R11: Flush clears all line and translation valid bits in one cycle. A request or fill presented in a flush cycle is dropped.
- R12: A lookup issued in the same cycle as a refill to its set sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines and translations |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 = store permission check, 0 = load |
| req_user | input | 1 | Access from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line present and access allowed |
| rsp_miss | output | 1 | Translated, allowed, line absent |
| rsp_tlb_miss | output | 1 | No translation for the page |
| rsp_fault | output | 1 | Permission violation |
| rsp_data | output | 32 | Selected word on a hit, else 0 |
| rsp_paddr | output | 32 | Translated byte address, 0 on translation miss |
| fill_valid | input | 1 | Line refill strobe |
| fill_line_addr | input | 26 | Physical line address (address bits 31..6) |
| fill_line | input | 512 | Full line contents |
| tlb_fill_valid | input | 1 | Translation fill strobe |
| tlb_fill_vpn | input | 20 | Virtual page number |
| tlb_fill_ppn | input | 20 | Physical page number |
| tlb_fill_perm | input | 3 | Permission bits (read, write, user) |

## Verification
The bench targets synonyms: two virtual pages mapped to one physical page must reach the same line, and a design that compared virtual bits would miss on the second one. It also checks that a line exists only under its physical tag, and that faults win over both hits and misses. A block that tested permission after the tag compare would return data for a forbidden access. Replacement is probed through eviction order. A pointer that advanced on an overwrite, in the cache or in the translation buffer, would evict a live line or entry that the bench later expects to hit. A same-cycle refill and lookup must still report a miss, and a request made during flush must give no response.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  // permission field layout shared by the translation buffer and the lookup
  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_USR = 2;

  typedef enum logic [1:0] {
    OUT_HIT  = 2'd0,
    OUT_MISS = 2'd1,
    OUT_XMIS = 2'd2,
    OUT_FLT  = 2'd3
  } outcome_e;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
  import vipt_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
  logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;
  logic [IDX_W-1:0]               rr_ptr;
  logic [ENTRIES-1:0]             lk_match;
  logic [ENTRIES-1:0]             fill_match;
  logic [IDX_W-1:0]               fill_idx;
  logic                           fill_present;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lk_match[e]   = ent_valid[e] && (ent_vpn[e] == lk_vpn);
    assign fill_match[e] = ent_valid[e] && (ent_vpn[e] == fill_vpn);
  end

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lk_match[e]) begin
        lk_ppn  = lk_ppn | ent_ppn[e];
        lk_perm = lk_perm | ent_perm[e];
      end
    end
  end
  assign lk_hit = |lk_match;

  always_comb begin
    fill_idx = rr_ptr;
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_match[e]) fill_idx = IDX_W'(e);
    end
  end
  assign fill_present = |fill_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (flush) begin
      ent_valid <= '0;
    end else if (fill_en) begin
      ent_valid[fill_idx] <= 1'b1;
      ent_vpn[fill_idx]   <= fill_vpn;
      ent_ppn[fill_idx]   <= fill_ppn;
      ent_perm[fill_idx]  <= fill_perm;
      if (!fill_present)
        rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // R10
  tlb_one_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R11
  tlb_flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !lk_hit);
endmodule

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int WAYS  = 4,
  parameter int SET_W = 6,
  parameter int TAG_W = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [SET_W-1:0]           rd_set,
  output logic [WAYS-1:0][TAG_W-1:0] rd_tag,
  output logic [WAYS-1:0]            rd_valid,
  input  logic                       fill_en,
  input  logic [SET_W-1:0]           fill_set,
  input  logic [TAG_W-1:0]           fill_tag,
  output logic [$clog2(WAYS)-1:0]    fill_way
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0]  vld [SETS];
  logic [WAY_W-1:0] rr  [SETS];
  logic [WAYS-1:0]  fill_hit_w;
  logic             do_fill;

  assign do_fill = fill_en && !flush;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];

    always_ff @(posedge clk) begin
      if (do_fill && fill_way == WAY_W'(w))
        tag_mem[fill_set] <= fill_tag;
    end

    assign rd_tag[w]     = tag_mem[rd_set];
    assign rd_valid[w]   = vld[rd_set][w];
    assign fill_hit_w[w] = vld[fill_set][w] && (tag_mem[fill_set] == fill_tag);
  end

  always_comb begin
    fill_way = rr[fill_set];
    for (int w = 0; w < WAYS; w++) begin
      if (fill_hit_w[w]) fill_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld[s] <= '0;
        rr[s]  <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fill_en) begin
      vld[fill_set][fill_way] <= 1'b1;
      if (!(|fill_hit_w))
        rr[fill_set] <= (rr[fill_set] == WAY_W'(WAYS - 1)) ? '0 : rr[fill_set] + 1'b1;
    end
  end

  // R11
  tag_flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rd_valid == '0));
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int WAYS   = 4,
  parameter int SET_W  = 6,
  parameter int LINE_W = 512
) (
  input  logic                        clk,
  input  logic                        rd_en,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][LINE_W-1:0] rd_lines,
  input  logic                        wr_en,
  input  logic [$clog2(WAYS)-1:0]     wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [LINE_W-1:0]           wr_line
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [LINE_W-1:0] mem [SETS];
    logic [LINE_W-1:0] q;

    // read-first single-clock RAM, one per way
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w))
        mem[wr_set] <= wr_line;
      if (rd_en)
        q <= mem[rd_set];
    end

    assign rd_lines[w] = q;
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_OFF_W = 6,
  parameter int WAYS       = 4,
  parameter int TLB_N      = 8,
  parameter int WORD_W     = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         req_valid,
  input  logic [VA_W-1:0]              req_vaddr,
  input  logic                         req_write,
  input  logic                         req_user,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic                         rsp_miss,
  output logic                         rsp_tlb_miss,
  output logic                         rsp_fault,
  output logic [WORD_W-1:0]            rsp_data,
  output logic [VA_W-1:0]              rsp_paddr,
  input  logic                         fill_valid,
  input  logic [VA_W-LINE_OFF_W-1:0]   fill_line_addr,
  input  logic [(8<<LINE_OFF_W)-1:0]   fill_line,
  input  logic                         tlb_fill_valid,
  input  logic [VA_W-PAGE_OFF_W-1:0]   tlb_fill_vpn,
  input  logic [VA_W-PAGE_OFF_W-1:0]   tlb_fill_ppn,
  input  logic [PERM_W-1:0]            tlb_fill_perm
);
  // index plus line offset fill the page offset exactly: set bits never translate
  localparam int PN_W   = VA_W - PAGE_OFF_W;
  localparam int SET_W  = PAGE_OFF_W - LINE_OFF_W;
  localparam int LINE_W = 8 << LINE_OFF_W;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = LINE_OFF_W - BYTE_W;
  localparam int WAY_W  = $clog2(WAYS);

  logic                       accept;
  logic [PN_W-1:0]            req_vpn;
  logic [SET_W-1:0]           req_set;
  logic                       tlb_hit;
  logic [PN_W-1:0]            tlb_ppn;
  logic [PERM_W-1:0]          tlb_perm;
  logic [WAYS-1:0][PN_W-1:0]  way_tag;
  logic [WAYS-1:0]            way_vld;
  logic [WAYS-1:0]            way_match;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           fill_way;
  logic                       perm_bad;
  outcome_e                   outcome;
  logic [WAYS-1:0][LINE_W-1:0] lines_q;

  logic [WAY_W-1:0]  way_q;
  logic [WSEL_W-1:0] wsel_q;

  assign accept  = req_valid && !flush;
  assign req_vpn = req_vaddr[VA_W-1:PAGE_OFF_W];
  assign req_set = req_vaddr[PAGE_OFF_W-1:LINE_OFF_W];

  vipt_tlb #(.VPN_W(PN_W), .PPN_W(PN_W), .ENTRIES(TLB_N)) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .lk_vpn   (req_vpn),
    .lk_hit   (tlb_hit),
    .lk_ppn   (tlb_ppn),
    .lk_perm  (tlb_perm),
    .fill_en  (tlb_fill_valid),
    .fill_vpn (tlb_fill_vpn),
    .fill_ppn (tlb_fill_ppn),
    .fill_perm(tlb_fill_perm)
  );

  vipt_tag_store #(.WAYS(WAYS), .SET_W(SET_W), .TAG_W(PN_W)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .rd_set  (req_set),
    .rd_tag  (way_tag),
    .rd_valid(way_vld),
    .fill_en (fill_valid),
    .fill_set(fill_line_addr[SET_W-1:0]),
    .fill_tag(fill_line_addr[VA_W-LINE_OFF_W-1:SET_W]),
    .fill_way(fill_way)
  );

  vipt_data_store #(.WAYS(WAYS), .SET_W(SET_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_en   (accept),
    .rd_set  (req_set),
    .rd_lines(lines_q),
    .wr_en   (fill_valid && !flush),
    .wr_way  (fill_way),
    .wr_set  (fill_line_addr[SET_W-1:0]),
    .wr_line (fill_line)
  );

  // physical compare against every way once the translation is known
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign way_match[w] = way_vld[w] && (way_tag[w] == tlb_ppn);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_match[w]) hit_way = WAY_W'(w);
    end
  end

  always_comb begin
    perm_bad = req_write ? !tlb_perm[PERM_WR] : !tlb_perm[PERM_RD];
    if (req_user && !tlb_perm[PERM_USR]) perm_bad = 1'b1;
  end

  always_comb begin
    if (!tlb_hit)        outcome = OUT_XMIS;
    else if (perm_bad)   outcome = OUT_FLT;
    else if (|way_match) outcome = OUT_HIT;
    else                 outcome = OUT_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_tlb_miss <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_paddr    <= '0;
      way_q        <= '0;
      wsel_q       <= '0;
    end else begin
      rsp_valid    <= accept;
      rsp_hit      <= accept && (outcome == OUT_HIT);
      rsp_miss     <= accept && (outcome == OUT_MISS);
      rsp_tlb_miss <= accept && (outcome == OUT_XMIS);
      rsp_fault    <= accept && (outcome == OUT_FLT);
      if (accept) begin
        rsp_paddr <= tlb_hit ? {tlb_ppn, req_vaddr[PAGE_OFF_W-1:0]} : '0;
        way_q     <= hit_way;
        wsel_q    <= req_vaddr[LINE_OFF_W-1:BYTE_W];
      end
    end
  end

  assign rsp_data = rsp_hit ? lines_q[way_q][wsel_q*WORD_W +: WORD_W] : '0;

  // R2
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault}));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush) |=> rsp_valid);

  // R11
  flush_drops_req_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !rsp_valid);

  // R4
  single_way_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_match));

  // R3
  xlate_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush && !tlb_hit) |=> (rsp_tlb_miss && rsp_data == '0));

  // R7
  perm_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flush && tlb_hit && perm_bad) |=> (rsp_fault && !rsp_hit));
endmodule

// File: tb/tb_vipt_l1_lookup.sv
`timescale 1ns/1ps
module tb_vipt_l1_lookup;
  localparam logic [1:0] K_HIT = 2'd0, K_MISS = 2'd1, K_XMIS = 2'd2, K_FLT = 2'd3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic         req_write = 1'b0;
  logic         req_user = 1'b0;
  logic         rsp_valid, rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault;
  logic [31:0]  rsp_data, rsp_paddr;
  logic         fill_valid = 1'b0;
  logic [25:0]  fill_line_addr = '0;
  logic [511:0] fill_line = '0;
  logic         tlb_fill_valid = 1'b0;
  logic [19:0]  tlb_fill_vpn = '0;
  logic [19:0]  tlb_fill_ppn = '0;
  logic [2:0]   tlb_fill_perm = '0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup dut (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_tlb_miss(rsp_tlb_miss), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data), .rsp_paddr(rsp_paddr),
    .fill_valid(fill_valid), .fill_line_addr(fill_line_addr), .fill_line(fill_line),
    .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn),
    .tlb_fill_ppn(tlb_fill_ppn), .tlb_fill_perm(tlb_fill_perm)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] data;
    logic [31:0] pa;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    fails  = 0;

  function automatic logic [511:0] make_line(input logic [31:0] seed);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[k*32 +: 32] = seed + k;
    return l;
  endfunction

  task automatic lookup(input logic [31:0] va, input logic wr, input logic usr,
                        input logic [1:0] kind, input logic [31:0] data,
                        input logic [31:0] pa, input string tag);
    exp_t e;
    e.kind = kind; e.data = data; e.pa = pa;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
  endtask

  task automatic refill(input logic [31:0] pa, input logic [31:0] seed);
    fill_valid = 1'b1; fill_line_addr = pa[31:6]; fill_line = make_line(seed);
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic map_page(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm);
    tlb_fill_valid = 1'b1; tlb_fill_vpn = vpn; tlb_fill_ppn = ppn; tlb_fill_perm = perm;
    @(posedge clk); #1;
    tlb_fill_valid = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a response shows up
  exp_t        cur;
  string       cur_tag;
  logic [1:0]  act_kind;
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2/R11 unexpected response actual=valid expected=none");
      end else begin
        cur = exp_q.pop_front();
        cur_tag = tag_q.pop_front();
        act_kind = rsp_hit ? K_HIT : rsp_miss ? K_MISS : rsp_tlb_miss ? K_XMIS : K_FLT;
        if ($countones({rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault}) != 1) begin
          fails++;
          $display("FAIL R2 (%s) outcome flags actual=%b expected=one-hot", cur_tag,
                   {rsp_hit, rsp_miss, rsp_tlb_miss, rsp_fault});
        end else if (act_kind != cur.kind || rsp_data != cur.data || rsp_paddr != cur.pa) begin
          fails++;
          $display("FAIL %s actual kind=%0d data=%h pa=%h expected kind=%0d data=%h pa=%h",
                   cur_tag, act_kind, rsp_data, rsp_paddr, cur.kind, cur.data, cur.pa);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset response actual=%b expected=0", rsp_valid);
    end
    @(posedge clk); #1;

    lookup(32'h0000_1040, 0, 0, K_XMIS, 32'h0, 32'h0, "R1 R3 empty buffer");

    map_page(20'h00001, 20'h12345, 3'b011);
    map_page(20'h00002, 20'h12345, 3'b111);
    map_page(20'h00003, 20'h0ABCD, 3'b010);
    map_page(20'h00004, 20'h55555, 3'b001);

    lookup(32'h0000_1040, 0, 0, K_MISS, 32'h0, 32'h1234_5040, "R5 cold miss");
    refill(32'h1234_5040, 32'h100);
    lookup(32'h0000_1048, 0, 0, K_HIT, 32'h102, 32'h1234_5048, "R4 word 2");
    lookup(32'h0000_107C, 0, 0, K_HIT, 32'h10F, 32'h1234_507C, "R4 word 15");
    lookup(32'h0000_2044, 0, 1, K_HIT, 32'h101, 32'h1234_5044, "R6 synonym page");
    lookup(32'h0000_1040, 0, 1, K_FLT, 32'h0, 32'h1234_5040, "R7 user without user bit");
    lookup(32'h0000_1040, 1, 0, K_HIT, 32'h100, 32'h1234_5040, "R7 store allowed");
    lookup(32'h0000_3040, 0, 0, K_FLT, 32'h0, 32'h0ABC_D040, "R7 load without read");
    lookup(32'h0000_4040, 1, 0, K_FLT, 32'h0, 32'h5555_5040, "R7 store without write");
    lookup(32'h0000_4040, 0, 0, K_MISS, 32'h0, 32'h5555_5040, "R6 physical tag compare");

    map_page(20'h00020, 20'h20000, 3'b111);
    map_page(20'h00021, 20'h20001, 3'b111);
    map_page(20'h00024, 20'h20004, 3'b111);
    for (int i = 0; i < 5; i++) refill(32'h2000_0140 + (i << 12), 32'h200 + i);
    lookup(32'h0002_0140, 0, 0, K_MISS, 32'h0, 32'h2000_0140, "R8 first tag evicted");
    lookup(32'h0002_1140, 0, 0, K_HIT, 32'h201, 32'h2000_1140, "R8 second tag kept");
    lookup(32'h0002_4144, 0, 0, K_HIT, 32'h205, 32'h2000_4144, "R8 fifth tag in way 0");

    refill(32'h1234_5040, 32'h300);
    lookup(32'h0000_1040, 0, 0, K_HIT, 32'h300, 32'h1234_5040, "R9 overwrite in place");
    refill(32'h2000_0040, 32'h310);
    refill(32'h2000_1040, 32'h311);
    refill(32'h2000_2040, 32'h312);
    lookup(32'h0000_1040, 0, 0, K_HIT, 32'h300, 32'h1234_5040, "R9 pointer not advanced");

    map_page(20'h00001, 20'h20000, 3'b111);
    lookup(32'h0000_1044, 0, 0, K_HIT, 32'h311, 32'h2000_0044, "R10 remapped entry");
    map_page(20'h00030, 20'h20001, 3'b111);
    map_page(20'h00031, 20'h20002, 3'b111);
    lookup(32'h0000_1040, 0, 0, K_XMIS, 32'h0, 32'h0, "R10 entry 0 evicted");
    lookup(32'h0000_2044, 0, 1, K_HIT, 32'h301, 32'h1234_5044, "R10 entry 1 kept");
    lookup(32'h0003_1048, 0, 0, K_HIT, 32'h314, 32'h2000_2048, "R10 wrapped entry");

    fill_valid = 1'b1; fill_line_addr = 26'(32'h2000_4180 >> 6); fill_line = make_line(32'h400);
    lookup(32'h0002_4180, 0, 0, K_MISS, 32'h0, 32'h2000_4180, "R12 same-cycle refill");
    fill_valid = 1'b0;
    lookup(32'h0002_4180, 0, 0, K_HIT, 32'h400, 32'h2000_4180, "R12 after refill");

    flush = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0000_2044; req_user = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0; req_valid = 1'b0; req_user = 1'b0;
    repeat (2) @(posedge clk); #1;
    lookup(32'h0000_2044, 0, 1, K_XMIS, 32'h0, 32'h0, "R11 translations cleared");
    map_page(20'h00002, 20'h12345, 3'b111);
    lookup(32'h0000_2044, 0, 1, K_MISS, 32'h0, 32'h1234_5044, "R11 lines cleared");

    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses actual=%0d pending expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule